// File: doc/BRIEF.md
# Per-Sector Lock Register Bank

This block keeps one byte-wide protection register for each 64 KB sector of a 1 MB nonvolatile array. Each register carries two live bits: a write-lock bit that gates program and erase to its sector, and a lock-down bit that, once set, freezes the register until the next reset. The program and erase path reads one enable per sector from `sector_writable`.

Software reaches the registers through a simple register port. It presents a valid strobe, a write flag, a full 32-bit system address and a data byte. The registers sit at a 64 KB stride in the system map, each at offset 0002H within its window. Read data comes back registered one cycle later. An address that does not decode to a register reads as 00H and takes no write. While the array reports an internal program or erase in progress, the port ignores both reads and writes.

Top module: `sector_lock_bank`

## Requirements
- R1: There are sixteen registers. An address decodes to register n when bits 31:20 equal FFBh, bits 15:0 equal 0002h and bits 19:16 equal n, so register n lies at FFB0_0002H + n×10000H and register 15 is at FFBF0002H.
- R2: An accepted read (reg_valid=1, reg_write=0, flash_busy=0) of register n places {6'b000000, lock-down, write-lock} on reg_rdata one cycle later, with lock-down in bit 1 and write-lock in bit 0. Bits 7:2 always read 0.
- R3: Reset (rst_n low) returns every register to 01H (write-locked, not locked down), drives sector_writable to all zeros and clears reg_rdata to 00H.
- R4: sector_writable[n] is 1 exactly when bit 0 of register n is 0. It follows a register write on the next cycle.
- R5: An accepted write (reg_valid=1, reg_write=1, flash_busy=0) to a register whose bit 1 is 0 loads bit 0 from reg_wdata[0] and bit 1 from reg_wdata[1]. Bits 7:2 of reg_wdata have no effect.
- R6: Once bit 1 of a register is 1, writes to that register leave both of its bits unchanged until reset.
- R7: Software can set bit 1 of a register but can never clear it.
- R8: An accepted read of an address that decodes to no register returns 00H. A write to such an address changes no register.
- R9: While flash_busy is 1, reads and writes are ignored: no register changes and reg_rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 32 | System address of the access |
| reg_wdata | input | 8 | Write data |
| flash_busy | input | 1 | Internal program or erase in progress |
| reg_rdata | output | 8 | Registered read data |
| sector_writable | output | 16 | Per-sector program/erase enable |

## Verification
The assertions assume that reg_write, reg_addr and reg_wdata are meaningful only in cycles where reg_valid is high. They also assume that flash_busy is a level sampled on the same edge as the request, so an access and a busy indication in one cycle mean the access is dropped. Beyond that, they make no assumption on ordering. The stimulus holds every input steady from one falling edge to the next. Its random phase draws addresses from a mix of exact register addresses and near misses, one bit off in the offset, index or upper field, so that the decode edges are reached while the inputs stay inside these assumptions.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;

  // Live content of one protection register.
  typedef struct packed {
    logic down;   // bit 1: freezes the register until reset
    logic wlock;  // bit 0: blocks program and erase of the sector
  } lock_state_t;

  localparam lock_state_t LOCK_RESET = '{down: 1'b0, wlock: 1'b1};

  // Next state of a register given a write request carrying the two
  // low data bits. A frozen register keeps its content.
  function automatic lock_state_t lock_next(input lock_state_t cur,
                                            input logic        req,
                                            input logic [1:0]  wbits);
    lock_state_t nxt;
    nxt = cur;
    if (req && !cur.down) begin
      nxt.down  = wbits[1];
      nxt.wlock = wbits[0];
    end
    return nxt;
  endfunction

  // Status byte for a register, reserved bits forced to zero.
  function automatic logic [7:0] lock_status_byte(input lock_state_t s);
    return {6'b000000, s.down, s.wlock};
  endfunction

endpackage

// File: rtl/lock_addr_decode.sv
module lock_addr_decode #(
  parameter int unsigned          ADDR_W      = 32,
  parameter int unsigned          NUM_SECTORS = 16,
  parameter int unsigned          SECT_BITS   = 16,
  parameter logic [ADDR_W-1:0]    BASE_ADDR   = 32'hFFB0_0002,
  localparam int unsigned         IDX_W       = $clog2(NUM_SECTORS)
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic                   hit,
  output logic [IDX_W-1:0]       idx,
  output logic [NUM_SECTORS-1:0] sel
);

  localparam int unsigned HI_LSB = SECT_BITS + IDX_W;
  localparam int unsigned HI_W   = ADDR_W - HI_LSB;
  localparam logic [HI_W-1:0]      BASE_HI  = BASE_ADDR[ADDR_W-1:HI_LSB];
  localparam logic [SECT_BITS-1:0] BASE_OFS = BASE_ADDR[SECT_BITS-1:0];

  function automatic logic upper_match(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:HI_LSB] == BASE_HI;
  endfunction

  function automatic logic offset_match(input logic [ADDR_W-1:0] a);
    return a[SECT_BITS-1:0] == BASE_OFS;
  endfunction

  function automatic logic [IDX_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[HI_LSB-1:SECT_BITS];
  endfunction

  logic in_window;
  logic idx_in_range;

  assign in_window    = upper_match(addr) && offset_match(addr);
  assign idx          = sector_of(addr);
  assign idx_in_range = (32'(idx) < NUM_SECTORS);
  assign hit          = in_window && idx_in_range;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sel
    assign sel[g] = hit && (idx == IDX_W'(g));
  end

endmodule

// File: rtl/lock_cell.sv
module lock_cell
  import lockbank_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_req,
  input  logic [1:0]  wbits,
  output lock_state_t state,
  output logic        frozen_hit
);

  lock_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LOCK_RESET;
    else        state_q <= lock_next(state_q, wr_req, wbits);
  end

  assign state      = state_q;
  assign frozen_hit = wr_req && state_q.down;

endmodule

// File: rtl/lock_read_mux.sv
module lock_read_mux
  import lockbank_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic [NUM_SECTORS-1:0] wl_vec,
  input  logic [NUM_SECTORS-1:0] ld_vec,
  input  logic                   hit,
  input  logic [IDX_W-1:0]       idx,
  output logic [DATA_W-1:0]      rdata
);

  logic [7:0] status_byte [NUM_SECTORS];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_status
    lock_state_t s;
    assign s.down          = ld_vec[g];
    assign s.wlock         = wl_vec[g];
    assign status_byte[g]  = lock_status_byte(s);
  end

  always_comb begin
    rdata = '0;
    if (hit) rdata = DATA_W'(status_byte[idx]);
  end

endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank
  import lockbank_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 32,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       NUM_SECTORS = 16,
  parameter int unsigned       SECT_BITS   = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'hFFB0_0002
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_valid,
  input  logic                   reg_write,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      reg_wdata,
  input  logic                   flash_busy,
  output logic [DATA_W-1:0]      reg_rdata,
  output logic [NUM_SECTORS-1:0] sector_writable
);

  localparam int unsigned IDX_W = $clog2(NUM_SECTORS);

  // Named internal events, also used by the checker.
  logic                   hit;
  logic [IDX_W-1:0]       idx;
  logic [NUM_SECTORS-1:0] sel;
  logic                   acc_ok;
  logic                   rd_fire;
  logic                   wr_fire;
  logic [NUM_SECTORS-1:0] wl_vec;
  logic [NUM_SECTORS-1:0] ld_vec;
  logic [NUM_SECTORS-1:0] frozen_vec;
  logic                   wr_blocked;
  logic [DATA_W-1:0]      rd_next;
  logic [DATA_W-1:0]      rdata_q;
  logic                   unused_wdata_hi;

  assign acc_ok  = reg_valid && !flash_busy;
  assign rd_fire = acc_ok && !reg_write;
  assign wr_fire = acc_ok && reg_write && hit;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

  lock_addr_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_SECTORS(NUM_SECTORS),
    .SECT_BITS  (SECT_BITS),
    .BASE_ADDR  (BASE_ADDR)
  ) u_dec (
    .addr(reg_addr),
    .hit (hit),
    .idx (idx),
    .sel (sel)
  );

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_cell
    lock_state_t st;
    lock_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_fire && sel[g]),
      .wbits     (reg_wdata[1:0]),
      .state     (st),
      .frozen_hit(frozen_vec[g])
    );
    assign wl_vec[g] = st.wlock;
    assign ld_vec[g] = st.down;
  end

  assign wr_blocked = |frozen_vec;

  lock_read_mux #(
    .NUM_SECTORS(NUM_SECTORS),
    .DATA_W     (DATA_W)
  ) u_rmux (
    .wl_vec(wl_vec),
    .ld_vec(ld_vec),
    .hit   (hit),
    .idx   (idx),
    .rdata (rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_next;
  end

  assign reg_rdata       = rdata_q;
  assign sector_writable = ~wl_vec;

endmodule

// File: rtl/sector_lock_bank_chk.sv
module sector_lock_bank_chk #(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flash_busy,
  input logic                   rd_fire,
  input logic                   wr_fire,
  input logic                   wr_blocked,
  input logic                   hit,
  input logic [IDX_W-1:0]       idx,
  input logic [DATA_W-1:0]      reg_wdata,
  input logic [NUM_SECTORS-1:0] wl_vec,
  input logic [NUM_SECTORS-1:0] ld_vec,
  input logic [NUM_SECTORS-1:0] sector_writable,
  input logic [DATA_W-1:0]      reg_rdata
);

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_blocked) |=> (wl_vec[$past(idx)] == $past(reg_wdata[0]) &&
                                  ld_vec[$past(idx)] == $past(reg_wdata[1]))); // R5

  AST_WRITABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_blocked) |=> sector_writable[$past(idx)] == !$past(reg_wdata[0])); // R4

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(wl_vec) && $stable(ld_vec))); // R6

  AST_DOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_vec & $past(ld_vec)) == $past(ld_vec))); // R7

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    flash_busy |=> ($stable(wl_vec) && $stable(ld_vec) && $stable(reg_rdata))); // R9

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !hit) |=> reg_rdata == '0); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:2] == '0); // R2

endmodule

bind sector_lock_bank sector_lock_bank_chk #(
  .NUM_SECTORS(NUM_SECTORS),
  .DATA_W     (DATA_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flash_busy     (flash_busy),
  .rd_fire        (rd_fire),
  .wr_fire        (wr_fire),
  .wr_blocked     (wr_blocked),
  .hit            (hit),
  .idx            (idx),
  .reg_wdata      (reg_wdata),
  .wl_vec         (wl_vec),
  .ld_vec         (ld_vec),
  .sector_writable(sector_writable),
  .reg_rdata      (reg_rdata)
);

// File: tb/sim_sector_lock_bank.sv
`timescale 1ns/1ps
module sim_sector_lock_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        flash_busy = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] sector_writable;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sector_lock_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flash_busy(flash_busy),
    .reg_rdata(reg_rdata), .sector_writable(sector_writable)
  );

  // Behavioural reference: two bits per sector plus the last read byte.
  int mdl_lock [16];
  int mdl_down [16];
  int mdl_rd;

  function automatic int reg_index(input logic [31:0] a);
    longint d;
    if (a < 32'hFFB0_0002) return -1;
    d = longint'(a) - 64'hFFB0_0002;
    if ((d % 65536) != 0 || (d / 65536) > 15) return -1;
    return int'(d / 65536);
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin mdl_lock[i] = 1; mdl_down[i] = 0; end
    mdl_rd = 0;
  end

  always @(posedge clk) begin
    int k;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mdl_lock[i] = 1; mdl_down[i] = 0; end
      mdl_rd = 0;
    end else if (reg_valid && !flash_busy) begin
      k = reg_index(reg_addr);
      if (reg_write) begin
        if (k >= 0 && mdl_down[k] == 0) begin
          mdl_lock[k] = reg_wdata[0];
          mdl_down[k] = reg_wdata[1];
        end
      end else begin
        mdl_rd = (k < 0) ? 0 : (mdl_down[k] * 2 + mdl_lock[k]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the edge.
  always @(negedge clk) begin
    logic [15:0] exp_w;
    for (int i = 0; i < 16; i++) exp_w[i] = (mdl_lock[i] == 0);
    chk("R4 per-cycle sector_writable", sector_writable, exp_w);
    chk("R2 per-cycle reg_rdata", reg_rdata, mdl_rd);
  end

  function automatic logic [31:0] reg_addr_of(input int n);
    return 32'hFFB0_0002 + 32'(n) * 32'h1_0000;
  endfunction

  task automatic access(input logic wr, input logic [31:0] a, input logic [7:0] d,
                        input logic busy);
    reg_valid  = 1'b1;
    reg_write  = wr;
    reg_addr   = a;
    reg_wdata  = d;
    flash_busy = busy;
    @(negedge clk);
    reg_valid  = 1'b0;
    flash_busy = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [31:0] a, input logic [7:0] exp);
    access(1'b0, a, 8'h00, 1'b0);
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R3 reset writable", sector_writable, 16'h0000);
    chk("R3 reset rdata", reg_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R3: every register reads 01H after reset
    for (int n = 0; n < 16; n++) rd_expect("R1 R3 default read", reg_addr_of(n), 8'h01);

    // R5 / R4: unlock sector 3
    access(1'b1, reg_addr_of(3), 8'h00, 1'b0);
    chk("R4 sector 3 writable", sector_writable, 16'h0008);
    rd_expect("R5 sector 3 unlocked", reg_addr_of(3), 8'h00);
    // R5: reserved write bits ignored
    access(1'b1, reg_addr_of(4), 8'hFC, 1'b0);
    rd_expect("R5 reserved bits ignored", reg_addr_of(4), 8'h00);
    access(1'b1, reg_addr_of(4), 8'h01, 1'b0);
    rd_expect("R5 relock sector 4", reg_addr_of(4), 8'h01);

    // R6: locked open then a relock attempt
    access(1'b1, reg_addr_of(5), 8'h02, 1'b0);
    rd_expect("R6 sector 5 locked open", reg_addr_of(5), 8'h02);
    access(1'b1, reg_addr_of(5), 8'h01, 1'b0);
    rd_expect("R6 sector 5 frozen", reg_addr_of(5), 8'h02);
    chk("R6 sector 5 still writable", sector_writable[5], 1'b1);

    // R7: locked down then attempt to clear lock-down
    access(1'b1, reg_addr_of(15), 8'h03, 1'b0);
    access(1'b1, reg_addr_of(15), 8'h00, 1'b0);
    rd_expect("R7 lock-down not cleared", reg_addr_of(15), 8'h03);
    access(1'b1, reg_addr_of(9), 8'hFF, 1'b0);
    rd_expect("R2 reserved read zero", reg_addr_of(9), 8'h03);

    // R8: near misses read zero and take no write
    rd_expect("R8 offset miss", 32'hFFB0_0003, 8'h00);
    rd_expect("R8 upper miss", 32'hFFC0_0002, 8'h00);
    rd_expect("R8 low offset miss", 32'hFFB1_0000, 8'h00);
    rd_expect("R8 below window", 32'hFFAF_0002, 8'h00);
    access(1'b1, 32'hFFB0_0003, 8'h00, 1'b0);
    access(1'b1, 32'hFFB0_1002, 8'h00, 1'b0);
    rd_expect("R8 miss writes no effect", reg_addr_of(0), 8'h01);

    // R9: busy drops writes and reads
    access(1'b1, reg_addr_of(0), 8'h00, 1'b1);
    chk("R9 busy write dropped", sector_writable[0], 1'b0);
    rd_expect("R9 sector 3 read", reg_addr_of(3), 8'h00);
    access(1'b0, reg_addr_of(0), 8'h00, 1'b1);
    chk("R9 busy read holds rdata", reg_rdata, 8'h00);
    rd_expect("R9 sector 0 untouched", reg_addr_of(0), 8'h01);

    // Random traffic compared each cycle with the reference
    for (int t = 0; t < 3000; t++) begin
      int pick;
      logic [31:0] a;
      pick = int'($urandom_range(0, 9));
      a = reg_addr_of(int'($urandom_range(0, 15)));
      if (pick == 7) a = a ^ (32'h1 << $urandom_range(0, 31));
      if (pick == 8) a = $urandom;
      access(($urandom_range(0, 1) == 1), a, 8'($urandom),
             ($urandom_range(0, 5) == 0));
      if ($urandom_range(0, 400) == 0) begin
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      end
    end

    // R3: reset releases lock-down
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_expect("R3 lock-down released", reg_addr_of(15), 8'h01);
    rd_expect("R3 locked-open released", reg_addr_of(5), 8'h01);
    chk("R3 writable after reset", sector_writable, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule